// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block is a memory-mapped parallel I/O peripheral with 24 external lines arranged as three 8-bit ports A, B and C. Port C is split into two nibbles: the upper nibble (bits 7..4) belongs to group A together with port A, and the lower nibble (bits 3..0) belongs to group B together with port B. A single internal control register sets each of the four sections as input or output. The lines therefore serve either as three byte-wide ports or as two byte-wide ports plus two 4-bit ports.

A host reaches the block through a 2-bit address, an 8-bit write bus, a write strobe, a read strobe and an 8-bit read bus. Address 0 selects port A, 1 selects port B, 2 selects all eight bits of port C, and 3 selects the control register. Each pin has separate input, output and output-enable signals, so the pads are built outside the block. Input pins pass through a two-flop synchronizer before the host can read them.

Top module: `tri_port_pio`

## Requirements
- R1: After reset every output enable is 0, so all four sections are inputs, and every output latch and every `*_out` bus is 0.
- R2: A write to address 3 whose bit 7 is 1 sets the directions: bit 4 = 1 makes port A an input, bit 3 = 1 makes port C upper an input, bit 1 = 1 makes port B an input, and bit 0 = 1 makes port C lower an input. A value of 0 makes the section an output. From the cycle after the write, the enables of an output section are all 1 and those of an input section are all 0.
- R3: Bits 6, 5 and 2 of an accepted control word have no effect on directions, on pins or on the value read back from address 3.
- R4: A write to address 3 with bit 7 = 0 changes neither the directions nor the output latches.
- R5: An accepted control word clears the output latches of ports A, B and C to 0 in the same cycle that it sets the directions.
- R6: A write to address 0, 1 or 2 loads that port's whole 8-bit output latch, whatever its direction. The latch drives `pa_out`, `pb_out` or `pc_out` from the next cycle.
- R7: A read of a section set as output returns that section's output latch.
- R8: A read of a section set as input returns its pins as they were at least two clock edges earlier (two-flop synchronizer). For every read, `rdata` is valid from the cycle after the read strobe and holds until the next read.
- R9: A read of address 2 returns each nibble of port C according to that nibble's own direction, so one nibble can come from the pins while the other comes from the latch.
- R10: A read of address 3 returns {1, 0, 0, A-input, C-upper-input, 0, B-input, C-lower-input}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, registered |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Directed passes cover the reset state and all sixteen direction combinations. In each combination, pin values differ from latch values, so a read shows whether a section takes its data from the pins or from the latch. Mixed port C settings show whether the nibbles are selected independently. Control words with bit 7 cleared and with the ignored bits toggled show that those bits have no effect, which separates a correct decode from one that accepts or stores too much. Random sequences of writes, reads and pin changes then check the latches and the read-back against the bench's own model.

// File: rtl/tri_port_pio.sv
module tri_port_pio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  logic [7:0] lat_a, lat_b, lat_c;
  logic       in_a, in_cu, in_b, in_cl;
  logic [23:0] sync1, sync2;
  logic [7:0] rd_val;
  logic       ctl_wr;

  assign ctl_wr = wr && addr == 2'd3 && wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0; lat_b <= '0; lat_c <= '0;
      in_a <= 1'b1; in_cu <= 1'b1; in_b <= 1'b1; in_cl <= 1'b1;
    end else if (ctl_wr) begin
      lat_a <= '0; lat_b <= '0; lat_c <= '0;
      in_a <= wdata[4]; in_cu <= wdata[3];
      in_b <= wdata[1]; in_cl <= wdata[0];
    end else if (wr) begin
      case (addr)
        2'd0: lat_a <= wdata;
        2'd1: lat_b <= wdata;
        2'd2: lat_c <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {pc_in, pb_in, pa_in};
      sync2 <= sync1;
    end
  end

  always_comb begin
    case (addr)
      2'd0: rd_val = in_a ? sync2[7:0] : lat_a;
      2'd1: rd_val = in_b ? sync2[15:8] : lat_b;
      2'd2: rd_val = {in_cu ? sync2[23:20] : lat_c[7:4],
                      in_cl ? sync2[19:16] : lat_c[3:0]};
      default: rd_val = {3'b100, in_a, in_cu, 1'b0, in_b, in_cl};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {8{~in_a}};
  assign pb_oe  = {8{~in_b}};
  assign pc_oe  = {{4{~in_cu}}, {4{~in_cl}}};

  a_r5_ctl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r4_bad_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && !wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  a_r6_port_a_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0) |=> (pa_out == $past(wdata)));

  a_r7_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr == 2'd1 && pb_oe == 8'hff) |=> (rdata == pb_out));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  a_r2_nibble_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wdata[7]) |=> (pc_oe[7:4] == {4{~$past(wdata[3])}} && pc_oe[3:0] == {4{~$past(wdata[0])}}));

endmodule

// File: tb/tri_port_pio_test.sv
`timescale 1ns/1ps
module tri_port_pio_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int vectors = 0;
  int errors = 0;
  logic [7:0] ma, mb, mc;
  logic da, dcu, db, dcl;

  always #2.5 clk = ~clk;

  tri_port_pio uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pb_in(pb_in),
    .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return da ? pa_in : ma;
      2'd1: return db ? pb_in : mb;
      2'd2: return {dcu ? pc_in[7:4] : mc[7:4], dcl ? pc_in[3:0] : mc[3:0]};
      default: return {3'b100, da, dcu, 1'b0, db, dcl};
    endcase
  endfunction

  function automatic logic [47:0] exp_pins();
    return {ma, mb, mc, {8{~da}}, {8{~db}}, {4{~dcu}}, {4{~dcl}}};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 2'd3) begin
      if (d[7]) begin
        ma = '0; mb = '0; mc = '0;
        da = d[4]; dcu = d[3]; db = d[1]; dcl = d[0];
      end
    end else if (a == 2'd0) ma = d;
    else if (a == 2'd1) mb = d;
    else mc = d;
  endtask

  task automatic do_read(input logic [1:0] a, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(tag, {56'd0, rdata}, {56'd0, exp_read(a)});
  endtask

  task automatic check_pins(input string tag);
    check(tag, {16'd0, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe}, {16'd0, exp_pins()});
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    pa_in = a; pb_in = b; pc_in = c;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    ma = '0; mb = '0; mc = '0; da = 1; dcu = 1; db = 1; dcl = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 reset outputs");
    set_pins(8'h5a, 8'hc3, 8'h96);
    do_read(2'd0, "R8 reset input A");
    do_read(2'd3, "R10 reset control readback");

    do_write(2'd0, 8'h11);
    check_pins("R6 latch loaded while input");
    do_read(2'd0, "R8 input ignores latch");

    for (int m = 0; m < 16; m++) begin
      do_write(2'd0, 8'hff); do_write(2'd1, 8'hff); do_write(2'd2, 8'hff);
      do_write(2'd3, {1'b1, 2'b00, m[3], m[2], 1'b0, m[1], m[0]});
      check_pins("R5 R2 control applied");
      do_write(2'd0, 8'h3c ^ 8'(m)); do_write(2'd1, 8'ha5); do_write(2'd2, 8'h69);
      check_pins("R6 latches drive outputs");
      do_read(2'd0, "R7 R8 port A read");
      do_read(2'd1, "R7 R8 port B read");
      do_read(2'd2, "R9 port C nibble read");
      do_read(2'd3, "R10 control readback");
    end

    do_write(2'd3, 8'h81);
    do_write(2'd0, 8'h77);
    do_write(2'd3, 8'b1110_0101);
    check_pins("R3 ignored bits applied word");
    do_read(2'd3, "R3 ignored bits readback");
    do_write(2'd2, 8'h4e);
    do_write(2'd3, 8'h00);
    check_pins("R4 bit7 clear ignored");
    do_write(2'd3, 8'h7f);
    check_pins("R4 bit7 clear ignored 7f");
    do_read(2'd3, "R4 control unchanged");

    @(negedge clk);
    pc_in = 8'hf0;
    @(negedge clk);
    addr = 2'd2; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R8 one edge not yet synced", {56'd0, rdata[7:4]}, 64'd0 | {60'd0, (dcu ? 4'h9 : mc[7:4])});
    repeat (2) @(negedge clk);
    do_read(2'd2, "R8 synced after two edges");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) do_write(2'($urandom_range(0, 2)), 8'($urandom));
      else if (op < 5) do_write(2'd3, 8'($urandom));
      else if (op < 8) do_read(2'($urandom_range(0, 3)), "R7 R8 R9 random read");
      else if (op < 9) set_pins(8'($urandom), 8'($urandom), 8'($urandom));
      else check_pins("R6 random pins");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule